// File: doc/BRIEF.md
# Broadcast Storm Rate Limiter

This block guards the forwarding fabric of a small multi-port switch against floods of frames sent to every port. Each port's receive path presents a one-cycle strobe at the start of each frame, with flags saying whether the destination is broadcast or multicast. The block keeps a running count of qualifying frames per port inside a fixed counting window. Once the count for the current window reaches a shared limit, it marks every further qualifying frame on that port for discard. The verdict appears in the same cycle as the strobe, so the queueing logic can act on it at once.

The window length follows each port's line speed. A port at 100 Mb/s uses a short window and a port at 10 Mb/s uses a long one. Both lengths are parameters counted in clock cycles. One limit value and one multicast-inclusion switch serve every port, and each port has its own enable. A limit of 99 frames per short window is a sensible software default. It corresponds to roughly one percent of minimum-size traffic at 100 Mb/s: 64-byte frames with preamble and inter-packet gap arrive at about 148,800 per second, and the short window spans 67 ms of that traffic.

Top module: `bcast_storm_limiter`

## Requirements
- R1: For each port, qualifying frames number 1 up to `storm_limit` within a window give `drop` low. Every further qualifying frame in the same window gives `drop` high. The decision is combinational in the cycle that `frm_start` is high, and `drop` is never high without `frm_start`.
- R2: A frame with `frm_bcast` = 1 always qualifies. A frame with only `frm_mcast` = 1 qualifies only while `mcast_incl` = 1. A frame with neither flag is never dropped and leaves the count unchanged.
- R3: A port with `spd_fast` = 1 (100 Mb/s) has a window of `FAST_WIN_CYC` cycles, and a port with `spd_fast` = 0 (10 Mb/s) has a window of `SLOW_WIN_CYC` cycles. The count returns to zero after the last cycle of each window. A frame in that last cycle is judged and counted in the window that is ending.
- R4: A change of a port's `spd_fast` input restarts that port's window timer and clears its count at the next clock edge.
- R5: While `port_en` for a port is low, that port's `drop` stays low, but its qualifying frames are still counted.
- R6: The per-port count stops at 2^`CNT_W`-1 and never wraps. With `storm_limit` at that maximum, every frame beyond the maximum is dropped until the window ends.
- R7: Ports count and time independently of one another. The single `storm_limit` and `mcast_incl` apply to all of them.
- R8: Reset clears every count and timer. With no frame strobes, all `drop` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | NUM_PORTS | One-cycle strobe at the start of a received frame, per port |
| frm_bcast | input | NUM_PORTS | Frame destination is broadcast, valid with `frm_start` |
| frm_mcast | input | NUM_PORTS | Frame destination is multicast, valid with `frm_start` |
| spd_fast | input | NUM_PORTS | Port line speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| port_en | input | NUM_PORTS | Per-port enable of the discard verdict |
| mcast_incl | input | 1 | Count multicast frames toward the limit when 1 |
| storm_limit | input | CNT_W | Frames allowed per window, shared by all ports |
| drop | output | NUM_PORTS | Discard verdict for the frame starting this cycle |

## Verification
The hardest state to reach from the ports is a window boundary that lands exactly on a frame while the port is over its limit. Only the cycle position of the frame decides whether the old or the new count applies. The bench pins each port's window phase by toggling its speed input twice. It then places frames at exact cycle offsets from that restart, so the last cycle of a window and the first cycle of the next can be hit on purpose. Saturation is reached the same way, by raising the limit to the counter maximum and sending a burst long enough to reach that maximum inside one window.

// File: rtl/storm_pkg.sv
package storm_pkg;

   typedef enum logic {
      SPD_10M  = 1'b0,
      SPD_100M = 1'b1
   } port_speed_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned ctr_width(input int unsigned span);
      return (span < 2) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/storm_qualify.sv
module storm_qualify #(
   parameter bit MCAST_OPTION = 1'b1
) (
   input  logic start,
   input  logic bcast,
   input  logic mcast,
   input  logic mcast_incl,
   output logic qualify
);

   generate
      if (MCAST_OPTION) begin : g_mcast
         assign qualify = start & (bcast | (mcast & mcast_incl));
      end else begin : g_bcast_only
         logic unused_mc;
         assign unused_mc = mcast & mcast_incl;
         assign qualify   = start & bcast;
      end
   endgenerate

endmodule

// File: rtl/storm_win_timer.sv
module storm_win_timer
   import storm_pkg::*;
#(
   parameter int unsigned FAST_CYC = 6700,
   parameter int unsigned SLOW_CYC = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spd_fast,
   output logic restart
);

   localparam int unsigned SPAN  = max_u(FAST_CYC, SLOW_CYC);
   localparam int unsigned TMR_W = ctr_width(SPAN);
   localparam logic [TMR_W-1:0] FAST_TERM = TMR_W'(FAST_CYC - 1);
   localparam logic [TMR_W-1:0] SLOW_TERM = TMR_W'(SLOW_CYC - 1);

   port_speed_e       spd_now;
   port_speed_e       spd_q;
   logic              primed_q;
   logic [TMR_W-1:0]  tmr_q;
   logic [TMR_W-1:0]  term;
   logic              spd_chg;
   logic              wrap;

   assign spd_now = port_speed_e'(spd_fast);
   assign term    = (spd_now == SPD_100M) ? FAST_TERM : SLOW_TERM;
   assign spd_chg = primed_q & (spd_now != spd_q);
   assign wrap    = (tmr_q >= term);
   assign restart = wrap | spd_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q    <= '0;
         spd_q    <= SPD_10M;
         primed_q <= 1'b0;
      end else begin
         primed_q <= 1'b1;
         spd_q    <= spd_now;
         tmr_q    <= restart ? '0 : tmr_q + 1'b1;
      end
   end

endmodule

// File: rtl/storm_frame_meter.sv
module storm_frame_meter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             qualify,
   input  logic             enable,
   input  logic [CNT_W-1:0] limit,
   output logic             drop,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             over;
   logic             bump;

   assign over  = (cnt_q >= limit);
   assign bump  = qualify & (cnt_q != CNT_MAX);
   assign drop  = enable & qualify & over;
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (bump) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bcast_storm_limiter.sv
module bcast_storm_limiter #(
   parameter int unsigned NUM_PORTS    = 3,
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned FAST_WIN_CYC = 6700,
   parameter int unsigned SLOW_WIN_CYC = 50000,
   parameter bit          MCAST_OPTION = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] frm_start,
   input  logic [NUM_PORTS-1:0] frm_bcast,
   input  logic [NUM_PORTS-1:0] frm_mcast,
   input  logic [NUM_PORTS-1:0] spd_fast,
   input  logic [NUM_PORTS-1:0] port_en,
   input  logic                 mcast_incl,
   input  logic [CNT_W-1:0]     storm_limit,
   output logic [NUM_PORTS-1:0] drop
);

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("NUM_PORTS must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and 16");
      end
      if (FAST_WIN_CYC < 2 || SLOW_WIN_CYC < 2) begin : g_bad_win
         $error("window lengths must be at least 2 cycles");
      end
      if (FAST_WIN_CYC > SLOW_WIN_CYC) begin : g_bad_order
         $error("the 100 Mb/s window may not exceed the 10 Mb/s window");
      end
   endgenerate

   logic [NUM_PORTS-1:0]            win_restart;
   logic [NUM_PORTS-1:0]            frm_qual;
   logic [NUM_PORTS-1:0][CNT_W-1:0] meter_cnt;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      storm_qualify #(
         .MCAST_OPTION (MCAST_OPTION)
      ) qual_i (
         .start      (frm_start[p]),
         .bcast      (frm_bcast[p]),
         .mcast      (frm_mcast[p]),
         .mcast_incl (mcast_incl),
         .qualify    (frm_qual[p])
      );

      storm_win_timer #(
         .FAST_CYC (FAST_WIN_CYC),
         .SLOW_CYC (SLOW_WIN_CYC)
      ) tmr_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .spd_fast (spd_fast[p]),
         .restart  (win_restart[p])
      );

      storm_frame_meter #(
         .CNT_W (CNT_W)
      ) mtr_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (win_restart[p]),
         .qualify (frm_qual[p]),
         .enable  (port_en[p]),
         .limit   (storm_limit),
         .drop    (drop[p]),
         .count   (meter_cnt[p])
      );
   end

endmodule

// File: rtl/bcast_storm_limiter_chk.sv
module bcast_storm_limiter_chk #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned CNT_W     = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_PORTS-1:0]            frm_start,
   input logic [NUM_PORTS-1:0]            frm_bcast,
   input logic [NUM_PORTS-1:0]            frm_mcast,
   input logic [NUM_PORTS-1:0]            port_en,
   input logic                            mcast_incl,
   input logic [NUM_PORTS-1:0]            drop,
   input logic [NUM_PORTS-1:0]            win_restart,
   input logic [NUM_PORTS-1:0][CNT_W-1:0] meter_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      AST_DROP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
         drop[p] |-> frm_start[p]); // R1
      AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         !win_restart[p] |=> (meter_cnt[p] == $past(meter_cnt[p]) ||
                              meter_cnt[p] == CNT_W'($past(meter_cnt[p]) + 1'b1))); // R1
      AST_PLAIN_FRAME_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
         (!frm_bcast[p] && !frm_mcast[p]) |-> !drop[p]); // R2
      AST_MCAST_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
         (!mcast_incl && !frm_bcast[p]) |-> !drop[p]); // R2
      AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
         (!frm_start[p] && !win_restart[p]) |=> $stable(meter_cnt[p])); // R2
      AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         win_restart[p] |=> (meter_cnt[p] == '0)); // R3
      AST_DISABLED_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         !port_en[p] |-> !drop[p]); // R5
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (meter_cnt[p] == CNT_MAX && !win_restart[p]) |=> (meter_cnt[p] == CNT_MAX)); // R6
   end

endmodule

bind bcast_storm_limiter bcast_storm_limiter_chk #(
   .NUM_PORTS (NUM_PORTS),
   .CNT_W     (CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .frm_start   (frm_start),
   .frm_bcast   (frm_bcast),
   .frm_mcast   (frm_mcast),
   .port_en     (port_en),
   .mcast_incl  (mcast_incl),
   .drop        (drop),
   .win_restart (win_restart),
   .meter_cnt   (meter_cnt)
);

// File: tb/bcast_storm_limiter_tb_top.sv
module bcast_storm_limiter_tb_top;

   localparam int unsigned NP   = 3;
   localparam int unsigned CW   = 4;
   localparam int unsigned FAST = 40;
   localparam int unsigned SLOW = 100;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] frm_start, frm_bcast, frm_mcast, spd_fast, port_en;
   logic          mcast_incl;
   logic [CW-1:0] storm_limit;
   logic [NP-1:0] drop;

   int vecs  = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bcast_storm_limiter #(
      .NUM_PORTS    (NP),
      .CNT_W        (CW),
      .FAST_WIN_CYC (FAST),
      .SLOW_WIN_CYC (SLOW)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_start   (frm_start),
      .frm_bcast   (frm_bcast),
      .frm_mcast   (frm_mcast),
      .spd_fast    (spd_fast),
      .port_en     (port_en),
      .mcast_incl  (mcast_incl),
      .storm_limit (storm_limit),
      .drop        (drop)
   );

   // row: port, start, bcast, mcast, mcast_incl, expected drop (limit 3)
   typedef struct packed {
      logic [1:0] port;
      logic       st;
      logic       bc;
      logic       mc;
      logic       incl;
      logic       exp;
   } row_t;

   localparam row_t VEC [12] = '{
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 first broadcast
      '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // idle
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 second
      '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 plain frame
      '{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 multicast, not counted
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 third, at limit
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 limit+1 dropped
      '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 plain frame over limit
      '{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 multicast excluded
      '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R2 multicast included
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 still dropping
      '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}   // R7 other port unaffected
   };

   task automatic apply(input int p, input logic st, input logic bc, input logic mc,
                        input logic exp, input string tag);
      frm_start    = '0;
      frm_bcast    = '0;
      frm_mcast    = '0;
      frm_start[p] = st;
      frm_bcast[p] = bc;
      frm_mcast[p] = mc;
      #5;
      vecs++;
      if (drop[p] !== exp) begin
         fails++;
         $display("FAIL %s: drop[%0d] = %b, expected %b", tag, p, drop[p], exp);
      end
      @(negedge clk);
      frm_start = '0;
      frm_bcast = '0;
      frm_mcast = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // two speed flips: the second restart leaves the port at window cycle 0
   task automatic align_port(input int p);
      spd_fast[p] = ~spd_fast[p];
      @(negedge clk);
      spd_fast[p] = ~spd_fast[p];
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual hung, expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      rst_n       = 1'b0;
      frm_start   = '0;
      frm_bcast   = '0;
      frm_mcast   = '0;
      spd_fast    = 3'b011;
      port_en     = 3'b111;
      mcast_incl  = 1'b0;
      storm_limit = 4'd3;
      idle(3);
      #5;
      vecs++;
      if (drop !== 3'b000) begin
         fails++;
         $display("FAIL R8 reset: drop = %b, expected 000", drop);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // table walk on port 0, aligned to window cycle 0
      align_port(0);
      for (int i = 0; i < 12; i++) begin
         mcast_incl = VEC[i].incl;
         apply(int'(VEC[i].port), VEC[i].st, VEC[i].bc, VEC[i].mc, VEC[i].exp, "R1/R2/R7 table");
      end
      idle(27);                                   // now window cycle 39
      apply(0, 1'b1, 1'b1, 1'b0, 1'b1, "R3 last cycle of fast window");
      apply(0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 first cycle of new window");
      mcast_incl = 1'b0;

      // slow port window
      align_port(2);
      for (int i = 0; i < 3; i++) apply(2, 1'b1, 1'b1, 1'b0, 1'b0, "R3 slow under limit");
      apply(2, 1'b1, 1'b1, 1'b0, 1'b1, "R3 slow over limit");
      idle(41);                                   // cycle 45
      apply(2, 1'b1, 1'b1, 1'b0, 1'b1, "R3 slow window still open");
      idle(53);                                   // cycle 99
      apply(2, 1'b1, 1'b1, 1'b0, 1'b1, "R3 slow last cycle");
      apply(2, 1'b1, 1'b1, 1'b0, 1'b0, "R3 slow window restarted");

      // shared limit on another port
      align_port(1);
      for (int i = 0; i < 3; i++) apply(1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 port1 under limit");
      apply(1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 port1 shared limit");

      // speed change restarts count
      align_port(0);
      for (int i = 0; i < 3; i++) apply(0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 fill");
      apply(0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 over limit before change");
      spd_fast[0] = 1'b0;
      @(negedge clk);
      apply(0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 count cleared by speed change");
      spd_fast[0] = 1'b1;
      @(negedge clk);

      // enable low still counts
      align_port(0);
      port_en[0] = 1'b0;
      for (int i = 0; i < 5; i++) apply(0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 disabled no drop");
      port_en[0] = 1'b1;
      apply(0, 1'b1, 1'b1, 1'b0, 1'b1, "R5 count kept while disabled");

      // saturation at counter maximum
      storm_limit = 4'd15;
      align_port(0);
      for (int i = 0; i < 20; i++)
         apply(0, 1'b1, 1'b1, 1'b0, (i >= 15), "R6 saturating burst");
      storm_limit = 4'd3;

      // reset mid-run
      align_port(0);
      for (int i = 0; i < 3; i++) apply(0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 fill");
      apply(0, 1'b1, 1'b1, 1'b0, 1'b1, "R8 over limit before reset");
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      apply(0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 count cleared by reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule